// File: doc/BRIEF.md
# Bit-Field Manipulation Unit

This execution unit takes one 32-bit instruction word with three register operands: the first source, the second source and the current destination value. It decodes the word and, when the word is recognised, produces the result of a bit-field operation together with a write-enable for the register file. The operations are signed and unsigned field extraction, field insertion into the old destination value, and setting or clearing a contiguous bit range. There are also byte and halfword sign and zero extension. A field is described by a start position and a length code. The length code is one less than the number of bits. Both values come either from immediates inside the instruction word or from the low bits of the second source register.

Decode and range checking are combinational. The result and write-enable are registered, so they appear one clock after the instruction is presented with its valid strobe. A word that is not recognised, or a field that runs past the top of the register, raises no write-enable and leaves the result output unchanged. The register file and hazard handling live outside this block.

Top module: `bitfield_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, `result` is 0 and `wrEn` is 0.
- R2: A word is an immediate-form field instruction when bits 6:0 are 0110011 and bits 31:30 are 11. The length code is taken from bits 29:25 and the start from bits 24:20. Bits 14:12 select the operation: 000 signed extract, 001 unsigned extract, 010 insert, 011 clear range, 100 set range. Values 101 to 111 cause no write.
- R3: A word is a register-form field instruction when bits 6:0 are 0110011 and bits 31:25 are 1000000. It uses the same operation codes as R2. The start comes from `srcB[4:0]` and the length code from `srcB[9:5]`, and the higher bits of `srcB` have no effect.
- R4: For the five field operations, when start plus length code is greater than 32, `wrEn` stays 0 and `result` keeps its previous value. A sum of exactly 32 is accepted.
- R5: Set range returns `srcA` with bits start through start+length code forced to 1. Bits above 31 are dropped.
- R6: Clear range returns `srcA` with bits start through start+length code forced to 0.
- R7: Insert returns `destOld` ORed with the low length-code+1 bits of `srcA` placed at bit position start.
- R8: Extract returns length-code+1 bits of `srcA`, beginning at bit start and moved down to bit 0. Source bits above 31 read as 0. The unsigned form fills the upper bits with 0. The signed form fills them with the top bit of the extracted field.
- R9: When bits 6:0 are 0110011 and bits 31:20 are 000100000000, bits 14:12 select an extension of `srcA`: 100 halfword sign-extend, 101 halfword zero-extend, 110 byte sign-extend, 111 byte zero-extend. Values 000 to 011 cause no write.
- R10: `wrEn` is 1 for exactly the cycle after a rising clock edge at which `inValid` was 1 with an accepted word. Otherwise it is 0, and `result` then holds its last written value.
- R11: A word matching none of the three layouts (wrong bits 6:0 or wrong upper prefix) causes no write and leaves `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| srcA | input | 32 | First source register value |
| srcB | input | 32 | Second source register value (start and length in register form) |
| destOld | input | 32 | Current value of the destination register |
| result | output | 32 | Registered result |
| wrEn | output | 1 | Registered write-enable for the destination |

## Verification
The only state is the output register pair, so a fault inside the block shows up at the ports on the very next clock. A wrong decode or range decision shows as a `wrEn` pulse that is missing or spurious. A bad mask or shift shows as wrong bits in `result`. A failure to hold shows as `result` drifting during cycles with no write, and the bench compares against the last expected value on every such cycle. The corners checked are spans summing to exactly 32 and to 33, the full 32-bit field, a signed field whose top bit is set, and junk in the unused upper bits of the second source.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  parameter int unsigned BfXlen = 32;
  localparam int unsigned BfPosW = $clog2(BfXlen);

  typedef enum logic [3:0] {
    BF_NONE,
    BF_XS,   // signed field extract
    BF_XU,   // unsigned field extract
    BF_INS,  // insert into old destination
    BF_CLR,  // clear bit range
    BF_SET,  // set bit range
    BF_SXH,  // halfword sign extend
    BF_ZXH,  // halfword zero extend
    BF_SXB,  // byte sign extend
    BF_ZXB   // byte zero extend
  } bfOp_e;

  typedef struct packed {
    logic              doWrite;
    bfOp_e             op;
    logic [BfPosW-1:0] start;
    logic [BfPosW-1:0] len;
  } bfCtrl_s;
endpackage

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
  import bfu_pkg::*;
(
  input  logic              inValid,
  input  logic [31:0]       instr,
  input  logic [BfXlen-1:0] srcB,
  output bfCtrl_s           ctrl
);
  localparam logic [6:0]  OpcField   = 7'b0110011;
  localparam logic [6:0]  RegPrefix  = 7'b1000000;
  localparam logic [11:0] ExtPrefix  = 12'b000100000000;
  localparam logic [BfPosW:0] SpanMax = (BfPosW+1)'(BfXlen);

  logic opcOk, immForm, regForm, extForm, rangeOp, rangeOk;
  logic [2:0] fn;
  logic [BfPosW-1:0] startSel, lenSel;
  logic [BfPosW:0] spanEnd;
  bfOp_e opSel;

  logic unusedBits;
  assign unusedBits = ^{instr[19:15], instr[11:7], srcB[BfXlen-1:2*BfPosW]};

  always_comb begin
    opcOk   = (instr[6:0] == OpcField);
    immForm = (instr[31:30] == 2'b11);
    regForm = (instr[31:25] == RegPrefix);
    extForm = (instr[31:20] == ExtPrefix);
    fn      = instr[14:12];

    startSel = immForm ? instr[24:20] : srcB[BfPosW-1:0];
    lenSel   = immForm ? instr[29:25] : srcB[2*BfPosW-1:BfPosW];
    spanEnd  = {1'b0, startSel} + {1'b0, lenSel};
    rangeOk  = (spanEnd <= SpanMax);

    opSel = BF_NONE;
    if (opcOk && (immForm || regForm)) begin
      case (fn)
        3'b000:  opSel = BF_XS;
        3'b001:  opSel = BF_XU;
        3'b010:  opSel = BF_INS;
        3'b011:  opSel = BF_CLR;
        3'b100:  opSel = BF_SET;
        default: opSel = BF_NONE;
      endcase
    end else if (opcOk && extForm) begin
      case (fn)
        3'b100:  opSel = BF_SXH;
        3'b101:  opSel = BF_ZXH;
        3'b110:  opSel = BF_SXB;
        3'b111:  opSel = BF_ZXB;
        default: opSel = BF_NONE;
      endcase
    end

    rangeOp = (opSel == BF_XS) || (opSel == BF_XU) || (opSel == BF_INS) ||
              (opSel == BF_CLR) || (opSel == BF_SET);

    ctrl.op      = opSel;
    ctrl.start   = startSel;
    ctrl.len     = lenSel;
    ctrl.doWrite = inValid && (opSel != BF_NONE) && (!rangeOp || rangeOk);
  end
endmodule

// File: rtl/bfu_dp.sv
module bfu_dp
  import bfu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bfCtrl_s           ctrl,
  input  logic [BfXlen-1:0] srcA,
  input  logic [BfXlen-1:0] destOld,
  output logic [BfXlen-1:0] result,
  output logic              wrEn
);
  localparam int unsigned XW = BfXlen;

  logic [BfPosW:0] lenPlus;
  logic [XW:0]     wideMask;
  logic [XW-1:0]   fieldMask, placedMask, pulled, nextVal;
  logic            fieldTop;

  always_comb begin
    lenPlus    = {1'b0, ctrl.len} + (BfPosW+1)'(1);
    wideMask   = ({{XW{1'b0}}, 1'b1} << lenPlus) - {{XW{1'b0}}, 1'b1};
    fieldMask  = wideMask[XW-1:0];
    placedMask = fieldMask << ctrl.start;
    pulled     = (srcA >> ctrl.start) & fieldMask;
    fieldTop   = pulled[ctrl.len];

    case (ctrl.op)
      BF_XS:   nextVal = pulled | (fieldTop ? ~fieldMask : '0);
      BF_XU:   nextVal = pulled;
      BF_INS:  nextVal = destOld | ((srcA & fieldMask) << ctrl.start);
      BF_CLR:  nextVal = srcA & ~placedMask;
      BF_SET:  nextVal = srcA | placedMask;
      BF_SXH:  nextVal = {{(XW-16){srcA[15]}}, srcA[15:0]};
      BF_ZXH:  nextVal = {{(XW-16){1'b0}}, srcA[15:0]};
      BF_SXB:  nextVal = {{(XW-8){srcA[7]}}, srcA[7:0]};
      BF_ZXB:  nextVal = {{(XW-8){1'b0}}, srcA[7:0]};
      default: nextVal = result;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      wrEn   <= 1'b0;
    end else begin
      wrEn <= ctrl.doWrite;
      if (ctrl.doWrite) result <= nextVal;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.doWrite |=> $stable(result));
  p_set_cover_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.doWrite && ctrl.op == BF_SET) |=> ((result & $past(srcA)) == $past(srcA)));
  p_clr_subset_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.doWrite && ctrl.op == BF_CLR) |=> ((result & ~$past(srcA)) == '0));
  p_ins_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.doWrite && ctrl.op == BF_INS) |=> ((result & $past(destOld)) == $past(destOld)));
  p_zext_byte_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.doWrite && ctrl.op == BF_ZXB) |=> (result[XW-1:8] == '0));
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [31:0]       instr,
  input  logic [BfXlen-1:0] srcA,
  input  logic [BfXlen-1:0] srcB,
  input  logic [BfXlen-1:0] destOld,
  output logic [BfXlen-1:0] result,
  output logic              wrEn
);
  bfCtrl_s ctrl;

  bfu_ctrl u_ctrl (
    .inValid (inValid),
    .instr   (instr),
    .srcB    (srcB),
    .ctrl    (ctrl)
  );

  bfu_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .srcA    (srcA),
    .destOld (destOld),
    .result  (result),
    .wrEn    (wrEn)
  );

  p_write_after_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(inValid));
  p_span_block_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instr[6:0] == 7'b0110011 && instr[31:30] == 2'b11 &&
     instr[14:12] <= 3'd4 &&
     (({1'b0, instr[29:25]} + {1'b0, instr[24:20]}) > 6'd32)) |=> !wrEn);
  p_bad_opcode_r11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instr[6:0] != 7'b0110011) |=> !wrEn);
endmodule

// File: tb/sim_bitfield_unit.sv
`timescale 1ns/1ps
module sim_bitfield_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] instr = '0, srcA = '0, srcB = '0, destOld = '0;
  logic [31:0] result;
  logic wrEn;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;
  logic [31:0] expRes = '0;

  always #2 clk = ~clk;

  bitfield_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .srcA(srcA), .srcB(srcB), .destOld(destOld),
    .result(result), .wrEn(wrEn)
  );

  function automatic void model(input logic [31:0] ins, a, b, d,
                                output logic we, output logic [31:0] r);
    int st, ln, f3;
    bit opk, imm, rg, ex, top;
    opk = (ins[6:0] == 7'h33);
    imm = (ins[31:30] == 2'b11);
    rg  = (ins[31:25] == 7'h40);
    ex  = (ins[31:20] == 12'h100);
    f3  = int'(ins[14:12]);
    we = 1'b0;
    r  = '0;
    if (!opk) return;
    if (imm || rg) begin
      st = imm ? int'(ins[24:20]) : int'(b[4:0]);
      ln = imm ? int'(ins[29:25]) : int'(b[9:5]);
      if (f3 > 4 || st + ln > 32) return;
      we = 1'b1;
      case (f3)
        0, 1: begin
          top = (st + ln < 32) ? a[st + ln] : 1'b0;
          for (int i = 0; i < 32; i++)
            if (i <= ln) r[i] = (st + i < 32) ? a[st + i] : 1'b0;
            else         r[i] = (f3 == 0) ? top : 1'b0;
        end
        2: begin
          r = d;
          for (int i = 0; i <= ln; i++)
            if (st + i < 32) r[st + i] = r[st + i] | a[i];
        end
        default: begin
          r = a;
          for (int i = 0; i < 32; i++)
            if (i >= st && i <= st + ln) r[i] = (f3 == 4);
        end
      endcase
    end else if (ex && f3 >= 4) begin
      we = 1'b1;
      case (f3)
        4: r = {{16{a[15]}}, a[15:0]};
        5: r = {16'h0, a[15:0]};
        6: r = {{24{a[7]}}, a[7:0]};
        default: r = {24'h0, a[7:0]};
      endcase
    end
  endfunction

  function automatic string reqOf(input logic [31:0] ins, input logic v);
    if (!v) return "R10";
    if (ins[6:0] != 7'h33) return "R11";
    if (ins[31:20] == 12'h100) return "R9";
    if (ins[31:30] != 2'b11 && ins[31:25] != 7'h40) return "R11";
    case (ins[14:12])
      3'd0, 3'd1: return "R8";
      3'd2: return "R7";
      3'd3: return "R6";
      3'd4: return "R5";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [31:0] mkImm(input logic [2:0] f3, input logic [4:0] ln, st);
    return {2'b11, ln, st, 5'd1, f3, 5'd2, 7'h33};
  endfunction
  function automatic logic [31:0] mkReg(input logic [2:0] f3);
    return {7'h40, 5'd3, 5'd1, f3, 5'd2, 7'h33};
  endfunction
  function automatic logic [31:0] mkExt(input logic [2:0] f3);
    return {12'h100, 5'd1, f3, 5'd2, 7'h33};
  endfunction

  task automatic applyVec(input logic [31:0] ins, a, b, d, input logic v, input string tag);
    logic we;
    logic [31:0] r;
    @(negedge clk);
    instr = ins; srcA = a; srcB = b; destOld = d; inValid = v;
    @(posedge clk);
    #1;
    model(ins, a, b, d, we, r);
    if (!v) we = 1'b0;
    if (we) expRes = r;
    nVec++;
    if (wrEn !== we || result !== expRes) begin
      nBad++;
      $display("FAIL %s instr=%h: wrEn=%b result=%h, expected wrEn=%b result=%h",
               tag, ins, wrEn, result, we, expRes);
    end
  endtask

  initial begin
    int unsigned seedSink;
    logic [31:0] ins, a, b, d;
    seedSink = $urandom(32'd2417);
    repeat (3) @(posedge clk);
    #1;
    nVec++;
    if (result !== 32'h0 || wrEn !== 1'b0) begin
      nBad++;
      $display("FAIL R1 in reset: wrEn=%b result=%h, expected wrEn=0 result=0", wrEn, result);
    end
    @(negedge clk);
    rstN = 1'b1;
    applyVec(mkImm(3'd4, 5'd3, 5'd2), 32'h1, 32'h0, 32'h0, 1'b0, "R1");

    // Directed corners
    applyVec(mkImm(3'd0, 5'd3, 5'd4), 32'h0000_00A0, 32'h0, 32'h0, 1'b1, "R8 signed top set");
    applyVec(mkImm(3'd1, 5'd3, 5'd4), 32'h0000_00A0, 32'h0, 32'h0, 1'b1, "R8 unsigned");
    applyVec(mkImm(3'd0, 5'd31, 5'd0), 32'h8765_4321, 32'h0, 32'h0, 1'b1, "R8 full width");
    applyVec(mkImm(3'd0, 5'd4, 5'd28), 32'hF000_0000, 32'h0, 32'h0, 1'b1, "R8 past top");
    applyVec(mkImm(3'd4, 5'd1, 5'd31), 32'h0000_0001, 32'h0, 32'h0, 1'b1, "R5 span 32");
    applyVec(mkImm(3'd3, 5'd13, 5'd20), 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1, "R4 span 33");
    applyVec(mkImm(3'd3, 5'd7, 5'd8), 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1, "R6");
    applyVec(mkImm(3'd2, 5'd7, 5'd12), 32'h0000_01A5, 32'h0, 32'h1234_0000, 1'b1, "R7");
    applyVec(mkReg(3'd4), 32'h0, 32'hFFFF_F000 | (32'd5 << 5) | 32'd9, 32'h0, 1'b1, "R3 upper junk");
    applyVec(mkReg(3'd1), 32'hDEAD_BEEF, (32'd7 << 5) | 32'd16, 32'h0, 1'b1, "R3 extract");
    applyVec(mkReg(3'd2), 32'hFFFF_FFFF, (32'd30 << 5) | 32'd3, 32'h0, 1'b1, "R3 R4 span 33");
    applyVec(mkExt(3'd4), 32'h0000_8001, 32'h0, 32'h0, 1'b1, "R9 halfword sign");
    applyVec(mkExt(3'd5), 32'hFFFF_8001, 32'h0, 32'h0, 1'b1, "R9 halfword zero");
    applyVec(mkExt(3'd6), 32'h0000_0080, 32'h0, 32'h0, 1'b1, "R9 byte sign");
    applyVec(mkExt(3'd7), 32'hFFFF_FF80, 32'h0, 32'h0, 1'b1, "R9 byte zero");
    applyVec(mkExt(3'd2), 32'h1111_1111, 32'h0, 32'h0, 1'b1, "R9 unused code");
    applyVec(mkImm(3'd5, 5'd2, 5'd2), 32'h1111_1111, 32'h0, 32'h0, 1'b1, "R2 unused code");
    applyVec(mkImm(3'd4, 5'd2, 5'd2) ^ 32'h4, 32'h0, 32'h0, 32'h0, 1'b1, "R11 opcode");
    applyVec(32'h4000_0033, 32'h0, 32'h0, 32'h0, 1'b1, "R11 prefix");
    applyVec(mkImm(3'd4, 5'd0, 5'd0), 32'h0, 32'h0, 32'h0, 1'b0, "R10 idle");

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      int form;
      logic v;
      form = int'($urandom_range(0, 4));
      a = $urandom; b = $urandom; d = $urandom;
      v = (form != 4) || ($urandom_range(0, 1) == 0);
      case (form)
        0: ins = {2'b11, 10'($urandom), 5'($urandom), 3'($urandom_range(0, 5)), 5'($urandom), 7'h33};
        1: ins = {7'h40, 10'($urandom), 3'($urandom_range(0, 5)), 5'($urandom), 7'h33};
        2: ins = {12'h100, 5'($urandom), 3'($urandom), 5'($urandom), 7'h33};
        default: ins = $urandom;
      endcase
      if (form == 1 && $urandom_range(0, 1) == 0) b[9:5] = 5'($urandom_range(0, 31 - int'(b[4:0])));
      applyVec(ins, a, b, d, v, reqOf(ins, v));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      nBad++;
      $display("FAIL R10 watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule